// File: doc/BRIEF.md
# Single-Block Directory Ownership Controller

This block keeps the directory record for one cache block in a coherence scheme that uses a directory. It holds a stable state (idle, shared or exclusive), the identity of the exclusive owner, and one transient state, busy, that it uses while ownership moves from the current owner to a new requester. During busy it also records which processor is waiting. Incoming messages are reads, writes, writebacks and transfer-done notices. Each one carries a source processor ID. For every message it accepts, the block sends exactly one outgoing message: a forward, a data reply, a NACK or an acknowledge, addressed to one destination ID.

The busy state is what lets the block handle a race safely. The old owner may send a writeback at the same moment the forwarded request reaches it. The directory still knows which requester to serve, because that requester is held in the busy record and not inferred from later traffic. A writeback that comes from the new requester before the transfer has closed is refused with a NACK. Data is modelled as a token, and sharer lists are not tracked.

Named states: IDLE, SHARED, EXCL, BUSY. Named transitions: IDLE/SHARED -RD-> SHARED, IDLE/SHARED -WR-> EXCL, EXCL -foreign RD/WR-> BUSY, EXCL -owner WB-> IDLE, BUSY -old-owner WB or DONE-> EXCL (owner becomes the pending requester). Every other message leaves the state unchanged.

Top module: `dir_entry_ctrl`

## Requirements
- R1: After reset the state is IDLE, `rsp_valid` is 0 and `msg_ready` is 1.
- R2: In IDLE or SHARED, a read (kind 0) gets a DATA reply (kind 1) to its source and the entry becomes SHARED. A write (kind 1) gets a DATA reply to its source and the entry becomes EXCL, with the source as owner.
- R3: In EXCL, a read or write from a processor other than the owner produces a FWD (kind 0) addressed to the owner. The entry enters BUSY and records the source as the pending requester.
- R4: In BUSY, a writeback (kind 2) from the old owner produces a DATA reply to the pending requester. The entry becomes EXCL, with the pending requester as owner.
- R5: In BUSY, a transfer-done notice (kind 3) from the old owner produces an ACK (kind 3) to the old owner. The entry becomes EXCL, with the pending requester as owner.
- R6: In BUSY, a writeback from the pending requester gets a NACK (kind 2) to that requester, and the entry stays BUSY with the same owner and the same pending requester.
- R7: In BUSY, any read or write gets a NACK to its source, and the state does not change.
- R8: In EXCL, a writeback from the owner gets an ACK to the owner, and the entry returns to IDLE.
- R9: A writeback or done notice that matches none of R4, R5, R6 or R8 gets a NACK to its source, and the state does not change.
- R10: In EXCL, a read or write from the owner itself gets a DATA reply to the owner, and the entry stays EXCL.
- R11: `msg_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response kind and destination stay stable. Each accepted message yields exactly one response, visible the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Message accepted this cycle when valid |
| msg_kind | input | 2 | 0 read, 1 write, 2 writeback, 3 transfer done |
| msg_src | input | ID_W | Source processor ID |
| rsp_valid | output | 1 | Outgoing message present |
| rsp_ready | input | 1 | Receiver takes the outgoing message |
| rsp_kind | output | 2 | 0 forward, 1 data, 2 NACK, 3 ACK |
| rsp_dst | output | ID_W | Destination processor ID |

## Verification
The assertions assume that `msg_kind` and `msg_src` are stable and known whenever `msg_valid` is high. They also assume that a source ID never exceeds NPROC-1. The bench meets these assumptions by driving inputs only on the falling edge, taking IDs from a two-bit field with NPROC=4, and lowering `msg_valid` after every accepted message. Sometimes it withholds `rsp_ready` for several cycles so that the stall path is exercised. Meanwhile a pseudo-random sweep of thousands of kind/source pairs walks every state into every message.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [1:0] {
        MSG_RD   = 2'd0,
        MSG_WR   = 2'd1,
        MSG_WB   = 2'd2,
        MSG_DONE = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        RSP_FWD  = 2'd0,
        RSP_DATA = 2'd1,
        RSP_NACK = 2'd2,
        RSP_ACK  = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHARED = 2'd1,
        ST_EXCL   = 2'd2,
        ST_BUSY   = 2'd3
    } dir_state_e;
endpackage

// File: rtl/dir_next.sv
module dir_next
    import dir_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  dir_state_e      cur_st,
    input  logic [ID_W-1:0] cur_owner,
    input  logic [ID_W-1:0] cur_pend,
    input  msg_kind_e       kind,
    input  logic [ID_W-1:0] src,
    output dir_state_e      nxt_st,
    output logic [ID_W-1:0] nxt_owner,
    output logic [ID_W-1:0] nxt_pend,
    output rsp_kind_e       rsp_kind,
    output logic [ID_W-1:0] rsp_dst
);
    logic from_owner;
    assign from_owner = (src == cur_owner);

    always_comb begin
        nxt_st    = cur_st;
        nxt_owner = cur_owner;
        nxt_pend  = cur_pend;
        rsp_kind  = RSP_NACK;
        rsp_dst   = src;
        unique case (cur_st)
            ST_IDLE, ST_SHARED: begin
                if (kind == MSG_RD) begin
                    rsp_kind = RSP_DATA;
                    nxt_st   = ST_SHARED;
                end else if (kind == MSG_WR) begin
                    rsp_kind  = RSP_DATA;
                    nxt_st    = ST_EXCL;
                    nxt_owner = src;
                end
            end
            ST_EXCL: begin
                if (kind == MSG_RD || kind == MSG_WR) begin
                    if (from_owner) begin
                        rsp_kind = RSP_DATA;
                    end else begin
                        rsp_kind = RSP_FWD;
                        rsp_dst  = cur_owner;
                        nxt_st   = ST_BUSY;
                        nxt_pend = src;
                    end
                end else if (kind == MSG_WB && from_owner) begin
                    rsp_kind = RSP_ACK;
                    nxt_st   = ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (kind == MSG_WB && from_owner) begin
                    rsp_kind  = RSP_DATA;
                    rsp_dst   = cur_pend;
                    nxt_st    = ST_EXCL;
                    nxt_owner = cur_pend;
                end else if (kind == MSG_DONE && from_owner) begin
                    rsp_kind  = RSP_ACK;
                    rsp_dst   = cur_owner;
                    nxt_st    = ST_EXCL;
                    nxt_owner = cur_pend;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dir_rsp_reg.sv
module dir_rsp_reg
    import dir_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  rsp_kind_e       load_kind,
    input  logic [ID_W-1:0] load_dst,
    input  logic            take,
    output logic            valid,
    output rsp_kind_e       kind,
    output logic [ID_W-1:0] dst
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            kind  <= RSP_NACK;
            dst   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            kind  <= load_kind;
            dst   <= load_dst;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !take) |=> (valid && $stable(kind) && $stable(dst)));
endmodule

// File: rtl/dir_entry_ctrl.sv
module dir_entry_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    localparam int ID_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msg_valid,
    output logic            msg_ready,
    input  logic [1:0]      msg_kind,
    input  logic [ID_W-1:0] msg_src,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [1:0]      rsp_kind,
    output logic [ID_W-1:0] rsp_dst
);
    dir_state_e      st_q, st_d;
    logic [ID_W-1:0] owner_q, owner_d;
    logic [ID_W-1:0] pend_q, pend_d;
    rsp_kind_e       nx_kind, rq_kind;
    logic [ID_W-1:0] nx_dst;
    logic            accept;

    assign msg_ready = !rsp_valid || rsp_ready;
    assign accept    = msg_valid && msg_ready;

    dir_next #(.ID_W(ID_W)) u_next (
        .cur_st    (st_q),
        .cur_owner (owner_q),
        .cur_pend  (pend_q),
        .kind      (msg_kind_e'(msg_kind)),
        .src       (msg_src),
        .nxt_st    (st_d),
        .nxt_owner (owner_d),
        .nxt_pend  (pend_d),
        .rsp_kind  (nx_kind),
        .rsp_dst   (nx_dst)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            owner_q <= '0;
            pend_q  <= '0;
        end else if (accept) begin
            st_q    <= st_d;
            owner_q <= owner_d;
            pend_q  <= pend_d;
        end
    end

    dir_rsp_reg #(.ID_W(ID_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_kind (nx_kind),
        .load_dst  (nx_dst),
        .take      (rsp_ready),
        .valid     (rsp_valid),
        .kind      (rq_kind),
        .dst       (rsp_dst)
    );
    assign rsp_kind = rq_kind;

    a_r11_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    a_r3_fwd_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q == ST_EXCL && msg_src != owner_q &&
         (msg_kind == MSG_RD || msg_kind == MSG_WR))
        |=> (st_q == ST_BUSY && rq_kind == RSP_FWD && pend_q == $past(msg_src)));
    a_r7_busy_nacks_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q == ST_BUSY && (msg_kind == MSG_RD || msg_kind == MSG_WR))
        |=> (rq_kind == RSP_NACK && rsp_dst == $past(msg_src) && st_q == ST_BUSY));
    a_r8_owner_wb_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q == ST_EXCL && msg_kind == MSG_WB && msg_src == owner_q)
        |=> (st_q == ST_IDLE && rq_kind == RSP_ACK));
    a_r4_wb_serves_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q == ST_BUSY && msg_kind == MSG_WB && msg_src == owner_q)
        |=> (rq_kind == RSP_DATA && rsp_dst == $past(pend_q) &&
             owner_q == $past(pend_q) && st_q == ST_EXCL));
    a_r6_pending_wb_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q == ST_BUSY && msg_kind == MSG_WB && msg_src == pend_q)
        |=> (st_q == ST_BUSY && $stable(pend_q) && $stable(owner_q)));
endmodule

// File: tb/tb_dir_entry_ctrl.sv
module tb_dir_entry_ctrl;
    localparam int NPROC = 4;
    localparam int ID_W  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            msg_valid = 1'b0;
    logic            msg_ready;
    logic [1:0]      msg_kind = 2'd0;
    logic [ID_W-1:0] msg_src = '0;
    logic            rsp_valid;
    logic            rsp_ready = 1'b1;
    logic [1:0]      rsp_kind;
    logic [ID_W-1:0] rsp_dst;

    int checks = 0;
    int errors = 0;

    // bench reference state: 0 idle, 1 shared, 2 excl, 3 busy
    int m_st = 0;
    int m_own = 0;
    int m_pend = 0;

    always #4 clk = ~clk;

    dir_entry_ctrl #(.NPROC(NPROC)) dut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_kind(msg_kind), .msg_src(msg_src),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_kind(rsp_kind), .rsp_dst(rsp_dst)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int k, input int s, input bit stall);
        int ek, ed, ns, no, np;
        string req;
        ek = 2; ed = s; ns = m_st; no = m_own; np = m_pend; req = "R9";
        if (m_st == 0 || m_st == 1) begin
            if (k == 0) begin ek = 1; ns = 1; req = "R2"; end
            else if (k == 1) begin ek = 1; ns = 2; no = s; req = "R2"; end
        end else if (m_st == 2) begin
            if (k <= 1 && s == m_own) begin ek = 1; req = "R10"; end
            else if (k <= 1) begin ek = 0; ed = m_own; ns = 3; np = s; req = "R3"; end
            else if (k == 2 && s == m_own) begin ek = 3; ns = 0; req = "R8"; end
        end else begin
            if (k <= 1) req = "R7";
            else if (k == 2 && s == m_own) begin ek = 1; ed = m_pend; ns = 2; no = m_pend; req = "R4"; end
            else if (k == 3 && s == m_own) begin ek = 3; ed = m_own; ns = 2; no = m_pend; req = "R5"; end
            else if (k == 2 && s == m_pend) req = "R6";
        end
        @(negedge clk);
        check("R11", int'(msg_ready), 1);
        msg_valid = 1'b1; msg_kind = k[1:0]; msg_src = s[ID_W-1:0];
        rsp_ready = !stall;
        @(negedge clk);
        msg_valid = 1'b0;
        check(req, int'(rsp_valid), 1);
        check(req, int'(rsp_kind), ek);
        check(req, int'(rsp_dst), ed);
        if (stall) begin
            for (int i = 0; i < 3; i++) begin
                check("R11", int'(msg_ready), 0);
                @(negedge clk);
                check("R11", int'(rsp_valid), 1);
                check("R11", int'(rsp_kind), ek);
                check("R11", int'(rsp_dst), ed);
            end
            rsp_ready = 1'b1;
            @(negedge clk);
        end else begin
            @(negedge clk);
        end
        check("R11", int'(rsp_valid), 0);
        m_st = ns; m_own = no; m_pend = np;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(rsp_valid), 0);
        check("R1", int'(msg_ready), 1);
        send(3, 0, 0);   // R9 stale done in idle
        send(0, 1, 0);   // R2 read -> shared
        send(1, 2, 0);   // R2 write -> excl owner 2
        send(0, 2, 0);   // R10
        send(0, 3, 0);   // R3 forward to 2, pend 3
        send(2, 3, 0);   // R6 wb from pending requester
        send(1, 0, 1);   // R7 with stall, R11
        send(2, 2, 0);   // R4 wb from old owner serves 3
        send(1, 1, 0);   // R3 forward to 3, pend 1
        send(3, 3, 0);   // R5 done from old owner
        send(2, 1, 0);   // R8 owner wb -> idle
        send(2, 1, 0);   // R9 stale wb in idle
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(int'(lfsr[1:0]), int'(lfsr[3:2]), (n % 17) == 5);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule